// File: doc/BRIEF.md
# LCD Pixel Depth and Ordering Unpacker

This block sits between a frame-buffer fetch path and a colour pipeline. It takes 32-bit frame-buffer words through a valid/ready handshake and emits one pixel per clock. The number of pixels per word, the order they come out in, and how each pixel is read are set by a depth code, two ordering controls and a channel-swap control.

Pixels of 1, 2, 4 and 8 bits leave as palette indices, flagged by `pix_index`. Pixels of 16 and 24 bits leave as direct colour: three 8-bit channels, each left-justified. In the base build, the 16-bit layout comes from an external 2-bit mux input. This lets a board rearrange the native 5551 format into 565 and force the blue-first order. A parameter selects the extended build instead. In that build, 565 and 444 have their own depth codes and the mux input has no effect.

The format controls are captured together with each word. A word is held until its last pixel has been shown. While a word is held, the next one is back-pressured.

Top module: `lcdu_unpacker`

## Requirements
- R1: After reset, `pix_valid` is 0 and `word_ready` is 1.
- R2: The first pixel of an accepted word appears in the cycle after acceptance. Pixels then follow one per cycle, 32/bits of them (one for depth code 5). `word_ready` stays 0 until the cycle in which the last pixel is shown. A word accepted in that cycle has its first pixel in the next cycle, with no gap.
- R3: Depth codes 0, 1, 2 and 3 give 1-, 2-, 4- and 8-bit pixels. These set `pix_index`=1 and place the index in `pix_data[7:0]`, with `pix_data[23:8]`=0.
- R4: With both ordering controls low, pixels are taken from the least significant end of the word first.
- R5: With `be_byte`=1, pixels are taken from the most significant end of the word first. This holds whatever `be_pix` is.
- R6: With only `be_pix`=1, bytes are taken least significant first. Within each byte, sub-byte pixels are taken most significant first. For 8-bit and wider pixels, `be_pix` has no effect.
- R7: Direct colour sets `pix_index`=0 and places channel A in `pix_data[23:16]`, channel B in `[15:8]` and channel C in `[7:0]`. Channel A is the field in the lowest bits of the pixel, and C the field in the highest bits. `bgr`=1 swaps channels A and C. A 5551 pixel has A=bits[4:0]<<3, B=bits[9:5]<<3 and C=bits[14:10]<<3, and bit 15 is ignored. For 16-bit pixels, `be_byte`=1 takes the upper half first.
- R8: In the base build, depth code 4 depends on `mux_sel`. A value of 1 gives 5551. Values 0 and 2 give 565 (A=bits[4:0]<<3, B=bits[10:5]<<2, C=bits[15:11]<<3) and honour `bgr`. A value of 3 gives 565 with A and C always swapped. Depth codes 6 and 7 behave as code 4.
- R9: Depth code 5 gives one pixel per word from the low 24 bits: A=[7:0], B=[15:8], C=[23:16], with `bgr` honoured. Bits [31:24] are ignored.
- R10: In the extended build (`EXT_MODES`=1), code 4 is 5551, code 6 is 565, and code 7 is 444 (A=bits[3:0]<<4, B=bits[7:4]<<4, C=bits[11:8]<<4). All three honour `bgr`, and `mux_sel` is ignored.
- R11: The depth, ordering, `bgr` and `mux_sel` inputs are sampled when a word is accepted. Changing them while that word is held does not alter its pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Depth code |
| cfg_be_byte | input | 1 | Most-significant-first word order |
| cfg_be_pix | input | 1 | Most-significant-first order inside bytes |
| cfg_bgr | input | 1 | Swap channels A and C |
| mux_sel | input | 2 | Board-level 16-bit layout select (base build) |
| word_valid | input | 1 | Frame-buffer word offered |
| word_data | input | 32 | Frame-buffer word |
| word_ready | output | 1 | Word accepted at this edge when valid |
| pix_valid | output | 1 | Pixel present |
| pix_index | output | 1 | Pixel is a palette index |
| pix_data | output | 24 | Index or {A,B,C} colour |

## Verification
A wrong slot counter shows up at the ports in one of two ways within the same word. A pixel appears in the wrong position, or `word_ready` rises a cycle early or late, which either cuts the word short or adds a bubble before the next one. A wrongly decoded format shows up on the first pixel after acceptance. The channels come out rotated, shifted by one bit, or flagged as an index. A format register that tracks the live inputs instead of the captured values becomes visible as soon as the controls change under a held word.

// File: rtl/lcdu_pkg.sv
package lcdu_pkg;
  localparam int WORD_BITS = 32;
  localparam int LG_WORD   = $clog2(WORD_BITS);

  typedef enum logic [2:0] {
    K_INDEX = 3'd0,
    K_5551  = 3'd1,
    K_565   = 3'd2,
    K_444   = 3'd3,
    K_888   = 3'd4
  } pix_kind_e;

  typedef struct packed {
    logic [2:0] lg_bits;   // log2 of slot width
    pix_kind_e  kind;
    logic       swap_ac;
    logic       be_byte;
    logic       be_pix;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] depth, input logic be_byte,
                                      input logic be_pix, input logic bgr,
                                      input logic [1:0] mux, input logic ext);
    fmt_t f;
    f.be_byte = be_byte;
    f.be_pix  = be_pix;
    f.swap_ac = bgr;
    f.lg_bits = 3'd4;
    f.kind    = K_5551;
    if (depth <= 3'd3) begin
      f.lg_bits = depth;
      f.kind    = K_INDEX;
    end else if (depth == 3'd5) begin
      f.lg_bits = 3'd5;
      f.kind    = K_888;
    end else if (ext) begin
      f.kind = (depth == 3'd6) ? K_565 : (depth == 3'd7) ? K_444 : K_5551;
    end else begin
      case (mux)
        2'd1:    f.kind = K_5551;
        2'd3:    begin f.kind = K_565; f.swap_ac = 1'b1; end
        default: f.kind = K_565;
      endcase
    end
    return f;
  endfunction

  function automatic logic [4:0] last_slot(input logic [2:0] lg);
    return 5'((6'd32 >> lg) - 6'd1);
  endfunction

  function automatic logic [4:0] slot_pos(input logic [4:0] k, input logic [2:0] lg,
                                          input logic be_byte, input logic be_pix);
    logic [4:0] sub_mask;
    sub_mask = (lg < 3'd3) ? 5'((4'd8 >> lg) - 4'd1) : 5'd0;
    if (be_byte)     return last_slot(lg) - k;
    else if (be_pix) return (k & ~sub_mask) | (sub_mask - (k & sub_mask));
    else             return k;
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] word, input logic [4:0] pos,
                                          input logic [2:0] lg);
    logic [32:0] mask;
    logic [9:0]  sh;
    mask = (33'd1 << (6'd1 << lg)) - 33'd1;
    sh   = 10'(pos) << lg;
    return (word >> sh) & mask[31:0];
  endfunction

  function automatic logic [23:0] to_color(input logic [31:0] raw, input pix_kind_e kind,
                                           input logic swap);
    logic [7:0] ca, cb, cc;
    case (kind)
      K_5551:  begin ca = {raw[4:0], 3'b0};  cb = {raw[9:5], 3'b0};  cc = {raw[14:10], 3'b0}; end
      K_565:   begin ca = {raw[4:0], 3'b0};  cb = {raw[10:5], 2'b0}; cc = {raw[15:11], 3'b0}; end
      K_444:   begin ca = {raw[3:0], 4'b0};  cb = {raw[7:4], 4'b0};  cc = {raw[11:8], 4'b0};  end
      K_888:   begin ca = raw[7:0];          cb = raw[15:8];         cc = raw[23:16];         end
      default: begin ca = 8'd0;              cb = 8'd0;              cc = raw[7:0];           end
    endcase
    if (kind == K_INDEX) return {16'd0, raw[7:0]};
    return swap ? {cc, cb, ca} : {ca, cb, cc};
  endfunction
endpackage

// File: rtl/lcdu_fmt_decode.sv
module lcdu_fmt_decode
  import lcdu_pkg::*;
#(
  parameter bit EXT_MODES = 1'b0
) (
  input  logic [2:0] depth,
  input  logic       be_byte,
  input  logic       be_pix,
  input  logic       bgr,
  input  logic [1:0] mux,
  output fmt_t       fmt
);
  always_comb fmt = decode_fmt(depth, be_byte, be_pix, bgr, mux, EXT_MODES);
endmodule

// File: rtl/lcdu_word_seq.sv
module lcdu_word_seq
  import lcdu_pkg::*;
#(
  parameter int W = WORD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  input  fmt_t         in_fmt,
  output logic         in_ready,
  output logic         held,
  output logic         last,
  output logic         accept,
  output logic [4:0]   cnt_q,
  output logic [W-1:0] word_q,
  output fmt_t         fmt_q
);
  assign last     = held && (cnt_q == last_slot(fmt_q.lg_bits));
  assign in_ready = !held || last;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
      fmt_q  <= '0;
    end else if (accept) begin
      held   <= 1'b1;
      cnt_q  <= '0;
      word_q <= in_word;
      fmt_q  <= in_fmt;
    end else if (last) begin
      held <= 1'b0;
    end else if (held) begin
      cnt_q <= cnt_q + 5'd1;
    end
  end
endmodule

// File: rtl/lcdu_pixel_pick.sv
module lcdu_pixel_pick
  import lcdu_pkg::*;
(
  input  logic [31:0] word,
  input  fmt_t        fmt,
  input  logic [4:0]  slot,
  output logic        is_index,
  output logic [23:0] data
);
  logic [4:0]  pos;
  logic [31:0] raw;
  always_comb begin
    pos      = slot_pos(slot, fmt.lg_bits, fmt.be_byte, fmt.be_pix);
    raw      = extract(word, pos, fmt.lg_bits);
    is_index = (fmt.kind == K_INDEX);
    data     = to_color(raw, fmt.kind, fmt.swap_ac);
  end
endmodule

// File: rtl/lcdu_unpacker.sv
module lcdu_unpacker
  import lcdu_pkg::*;
#(
  parameter bit EXT_MODES = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_depth,
  input  logic        cfg_be_byte,
  input  logic        cfg_be_pix,
  input  logic        cfg_bgr,
  input  logic [1:0]  mux_sel,
  input  logic        word_valid,
  input  logic [31:0] word_data,
  output logic        word_ready,
  output logic        pix_valid,
  output logic        pix_index,
  output logic [23:0] pix_data
);
  fmt_t        fmt_in, fmt_q;
  logic        held, last, accept;
  logic [4:0]  cnt_q;
  logic [31:0] word_q;

  lcdu_fmt_decode #(.EXT_MODES(EXT_MODES)) u_dec (
    .depth(cfg_depth), .be_byte(cfg_be_byte), .be_pix(cfg_be_pix),
    .bgr(cfg_bgr), .mux(mux_sel), .fmt(fmt_in)
  );

  lcdu_word_seq #(.W(WORD_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(word_valid), .in_word(word_data),
    .in_fmt(fmt_in), .in_ready(word_ready), .held(held), .last(last),
    .accept(accept), .cnt_q(cnt_q), .word_q(word_q), .fmt_q(fmt_q)
  );

  lcdu_pixel_pick u_pick (
    .word(word_q), .fmt(fmt_q), .slot(cnt_q),
    .is_index(pix_index), .data(pix_data)
  );

  assign pix_valid = held;
endmodule

// File: rtl/lcdu_unpacker_chk.sv
module lcdu_unpacker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        word_ready,
  input logic        pix_valid,
  input logic        pix_index,
  input logic [23:0] pix_data,
  input logic        held,
  input logic        last,
  input logic        accept,
  input logic [31:0] word_q
);
  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> word_ready);
  // R2
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pix_valid);
  // R2
  hold_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !last) |-> !word_ready);
  // R2
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !last) |=> pix_valid);
  // R11
  word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !last) |=> $stable(word_q));
  // R3
  index_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_index) |-> (pix_data[23:8] == 16'd0));
endmodule

bind lcdu_unpacker lcdu_unpacker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_ready(word_ready), .pix_valid(pix_valid),
  .pix_index(pix_index), .pix_data(pix_data), .held(held), .last(last),
  .accept(accept), .word_q(word_q)
);

// File: tb/sim_lcdu_unpacker.sv
module sim_lcdu_unpacker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  depth = '0;
  logic bb = 1'b0, bp = 1'b0, bgr = 1'b0;
  logic [1:0]  mux = '0;
  logic        wv = 1'b0;
  logic [31:0] wd = '0;
  logic        r0, v0, i0, r1, v1, i1;
  logic [23:0] d0, d1;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  lcdu_unpacker #(.EXT_MODES(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(depth), .cfg_be_byte(bb), .cfg_be_pix(bp),
    .cfg_bgr(bgr), .mux_sel(mux), .word_valid(wv), .word_data(wd),
    .word_ready(r0), .pix_valid(v0), .pix_index(i0), .pix_data(d0));

  lcdu_unpacker #(.EXT_MODES(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_depth(depth), .cfg_be_byte(bb), .cfg_be_pix(bp),
    .cfg_bgr(bgr), .mux_sel(mux), .word_valid(wv), .word_data(wd),
    .word_ready(r1), .pix_valid(v1), .pix_index(i1), .pix_data(d1));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] abc(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic sw);
    return sw ? {c, b, a} : {a, b, c};
  endfunction

  // Model: returns {valid, index flag, data}
  function automatic logic [31:0] model(logic [31:0] w, logic [2:0] d, logic obb,
                                        logic obp, logic obgr, logic [1:0] omux,
                                        bit ext, int k);
    int b, n, j;
    logic [31:0] raw;
    logic [15:0] h;
    if (d <= 3) begin
      b = 1 << d;
      n = 32 / b;
      if (obb)                 j = n - 1 - k;
      else if (obp && b < 8)   j = k ^ (8 / b - 1);
      else                     j = k;
      raw = (w >> (j * b)) & ((32'd1 << b) - 32'd1);
      return {6'b0, 1'b1, 1'b1, 16'd0, raw[7:0]};
    end
    if (d == 5) return {6'b0, 1'b1, 1'b0, abc(w[7:0], w[15:8], w[23:16], obgr)};
    h = ((obb ? 1 - k : k) == 1) ? w[31:16] : w[15:0];
    if (ext ? (d == 4) : (omux == 2'd1))
      return {8'b10, abc({h[4:0], 3'b0}, {h[9:5], 3'b0}, {h[14:10], 3'b0}, obgr)};
    if (ext && d == 7)
      return {8'b10, abc({h[3:0], 4'b0}, {h[7:4], 4'b0}, {h[11:8], 4'b0}, obgr)};
    return {8'b10, abc({h[4:0], 3'b0}, {h[10:5], 2'b0}, {h[15:11], 3'b0},
                       (!ext && omux == 2'd3) ? 1'b1 : obgr)};
  endfunction

  function automatic int npix(logic [2:0] d);
    return (d <= 3) ? (32 >> d) : (d == 5) ? 1 : 2;
  endfunction

  task automatic run_word(string req, logic [2:0] d, logic obb, logic obp, logic obgr,
                          logic [1:0] omux, logic [31:0] w);
    @(negedge clk);
    depth = d; bb = obb; bp = obp; bgr = obgr; mux = omux; wd = w; wv = 1'b1;
    @(negedge clk);
    wv = 1'b0;
    for (int k = 0; k < npix(d); k++) begin
      check(req, {6'b0, v0, i0, d0}, model(w, d, obb, obp, obgr, omux, 1'b0, k));
      check(req, {6'b0, v1, i1, d1}, model(w, d, obb, obp, obgr, omux, 1'b1, k));
      @(negedge clk);
    end
    check({req, " R2 end"}, {30'b0, v0, v1}, 32'd0);
  endtask

  task automatic back_to_back();
    @(negedge clk);
    depth = 3'd4; bb = 0; bp = 0; bgr = 0; mux = 2'd1; wd = 32'h1234_5678; wv = 1'b1;
    @(negedge clk);
    check("R2 ready low while held", {31'b0, r0}, 32'd0);
    check("R2 first word px0", {6'b0, v0, i0, d0}, model(32'h1234_5678, 3'd4, 0, 0, 0, 2'd1, 0, 0));
    wd = 32'h9ABC_DEF0;
    @(negedge clk);
    check("R2 ready on last", {31'b0, r0}, 32'd1);
    check("R2 first word px1", {6'b0, v0, i0, d0}, model(32'h1234_5678, 3'd4, 0, 0, 0, 2'd1, 0, 1));
    @(negedge clk);
    wv = 1'b0;
    check("R2 second word px0 no gap", {6'b0, v0, i0, d0}, model(32'h9ABC_DEF0, 3'd4, 0, 0, 0, 2'd1, 0, 0));
    @(negedge clk);
    check("R2 second word px1", {6'b0, v0, i0, d0}, model(32'h9ABC_DEF0, 3'd4, 0, 0, 0, 2'd1, 0, 1));
    @(negedge clk);
    check("R2 idle after", {31'b0, v0}, 32'd0);
  endtask

  task automatic cfg_latch();
    @(negedge clk);
    depth = 3'd3; bb = 0; bp = 0; bgr = 0; mux = 2'd0; wd = 32'hC0DE_1A2B; wv = 1'b1;
    @(negedge clk);
    wv = 1'b0; bb = 1'b1; depth = 3'd2; wd = 32'h0;
    for (int k = 0; k < 4; k++) begin
      check("R11 cfg change ignored", {6'b0, v0, i0, d0}, model(32'hC0DE_1A2B, 3'd3, 0, 0, 0, 2'd0, 0, k));
      @(negedge clk);
    end
    check("R11 word count kept", {31'b0, v0}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state u0", {30'b0, v0, r0}, 32'd1);
    check("R1 reset state u1", {30'b0, v1, r1}, 32'd1);
    run_word("R3 R4 8-bit LE", 3'd3, 0, 0, 0, 2'd0, 32'h8C4A_1F03);
    run_word("R3 R4 4-bit LE", 3'd2, 0, 0, 0, 2'd0, 32'hF1E2_D3C4);
    run_word("R5 2-bit be_byte", 3'd1, 1, 0, 0, 2'd0, 32'h1B2D_63E4);
    run_word("R5 1-bit both set, byte wins", 3'd0, 1, 1, 0, 2'd0, 32'h8000_00A1);
    run_word("R6 2-bit be_pix", 3'd1, 0, 1, 0, 2'd0, 32'h1B2D_63E4);
    run_word("R6 1-bit be_pix", 3'd0, 0, 1, 0, 2'd0, 32'h0102_8040);
    run_word("R6 8-bit be_pix no effect", 3'd3, 0, 1, 0, 2'd0, 32'h4433_2211);
    run_word("R7 R8 5551 mux1", 3'd4, 0, 0, 0, 2'd1, 32'hA5C3_FE19);
    run_word("R7 R8 5551 mux1 bgr be_byte", 3'd4, 1, 0, 1, 2'd1, 32'hA5C3_FE19);
    run_word("R8 565 mux0", 3'd4, 0, 0, 0, 2'd0, 32'h7BEF_0841);
    run_word("R8 565 mux2 bgr", 3'd4, 0, 0, 1, 2'd2, 32'hF800_07E0);
    run_word("R8 565 mux3 forced swap", 3'd4, 0, 0, 0, 2'd3, 32'hF800_001F);
    run_word("R8 R10 code6 mux3", 3'd6, 0, 0, 0, 2'd3, 32'h1234_ABCD);
    run_word("R8 R10 code7 mux1 bgr", 3'd7, 0, 0, 1, 2'd1, 32'h0FA5_5A3C);
    run_word("R10 code7 mux0", 3'd7, 1, 0, 0, 2'd0, 32'h0321_0CBA);
    run_word("R9 24-bit", 3'd5, 0, 0, 0, 2'd0, 32'hFF11_2233);
    run_word("R9 24-bit bgr", 3'd5, 1, 0, 1, 2'd3, 32'hEE44_5566);
    back_to_back();
    cfg_latch();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule